// File: doc/BRIEF.md
# One-Hot Residue Modular Adder

This block adds two signed integers in residue form. The moduli are 3, 4 and 5, which share no common factor, so the dynamic range is their product, 60. Each operand is reduced to its value modulo 60, with a negative operand taken as its value plus 60. The offset value then indexes a per-channel table that gives one residue for each modulus. Every residue is held as a one-hot vector: a channel for modulus m has m lines, and line k is the only line set when the residue is k.

Each channel adds by itself and passes no carry to its neighbours. The channel rotates the one-hot vector of operand A by the position of operand B's active line. Operand B can come from the binary port or straight from a one-hot residue port, so an earlier sum can be fed back in. Every one-hot vector the lanes receive is checked, and a malformed vector raises an error flag in place of a result. The result is registered and appears one cycle after the request.

Top module: `ohrns_oh_adder`

## Requirements
- R1: In the cycle after an accepted request, sum_oh holds one-hot residues of (A + B) mod 60. The modulus-3 channel sits in bits 2:0, modulus 4 in bits 6:3 and modulus 5 in bits 11:7. Bit k of a channel, counted from that channel's low bit, is set when the residue is k.
- R2: A negative binary operand X is converted as X + 60. For example, -1 gives residues 2, 3 and 4.
- R3: Sums wrap modulo 60. For example, 29 + 2 yields the residues of 31, which is the signed value -29.
- R4: A request with valid_in high and well-formed operands gives valid_out high on the next clock edge, with oh_err low. Requests can be issued back to back, one per cycle.
- R5: When b_use_oh is 1, operand B is taken from b_oh in the layout of R1, and b_bin has no effect on the result.
- R6: When b_use_oh is 1 and any channel of b_oh has zero bits or more than one bit set, a request gives oh_err high and valid_out low on the next edge, and sum_oh keeps its previous value.
- R7: When b_use_oh is 0, b_oh is ignored, even when it is malformed, and raises no error.
- R8: A cycle with valid_in low gives valid_out and oh_err low on the next edge, and sum_oh keeps its value.
- R9: A synchronous active-high reset clears valid_out and oh_err and sets sum_oh to residue 0 in every channel (12'h089).
- R10: A binary operand outside (-30, 30] that still fits the operand width is reduced modulo 60 as well. For example, -32 gives the residues of 28 and 31 gives the residues of 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Request strobe |
| a_bin | input | OP_W | Operand A, signed binary |
| b_bin | input | OP_W | Operand B, signed binary, used when b_use_oh is 0 |
| b_use_oh | input | 1 | 1 selects b_oh as operand B |
| b_oh | input | 12 | Operand B as one-hot residues |
| valid_out | output | 1 | Registered result strobe |
| sum_oh | output | 12 | Registered one-hot residue sum |
| oh_err | output | 1 | A malformed one-hot operand was seen on the last request |

## Verification
The bench keeps the default operand width of 6 bits, which covers the whole range -32 to 31. This brings the four values outside (-30, 30] within reach, where the modulo-60 reduction must still hold. The bench builds the adder with the indexed-rotate lane variant (ROT_IMPL = 1). The crossbar variant is the one elaborated at the default settings, so both ways of rotating are compiled. The feedback port lets the bench inject malformed vectors with a missing bit and with an extra bit. It also places them on the unused path, to show that the error logic watches only the selected operand.

// File: rtl/ohrns_pkg.sv
package ohrns_pkg;

   localparam int unsigned NMOD = 3;
   localparam int unsigned MODS [NMOD] = '{3, 4, 5};

   function automatic int unsigned mod_of(input int unsigned i);
      return MODS[i];
   endfunction

   // low bit of channel i in the flat one-hot vector
   function automatic int unsigned off_of(input int unsigned i);
      int unsigned acc;
      acc = 0;
      for (int unsigned k = 0; k < NMOD; k++)
         if (k < i) acc += MODS[k];
      return acc;
   endfunction

   function automatic int unsigned dyn_range();
      int unsigned p;
      p = 1;
      for (int unsigned k = 0; k < NMOD; k++) p *= MODS[k];
      return p;
   endfunction

   function automatic int unsigned gcd(input int unsigned x, input int unsigned y);
      int unsigned a, b, t;
      a = x;
      b = y;
      while (b != 0) begin
         t = a % b;
         a = b;
         b = t;
      end
      return a;
   endfunction

   function automatic bit moduli_coprime();
      bit ok;
      ok = 1'b1;
      for (int unsigned i = 0; i < NMOD; i++)
         for (int unsigned j = 0; j < NMOD; j++)
            if (i < j && gcd(MODS[i], MODS[j]) != 1) ok = 1'b0;
      return ok;
   endfunction

   localparam int unsigned LINES = off_of(NMOD);
   localparam int unsigned DYN   = dyn_range();
   localparam int unsigned IDX_W = $clog2(DYN);

   // residue zero in every channel
   function automatic logic [LINES-1:0] zero_code();
      logic [LINES-1:0] v;
      v = '0;
      for (int unsigned k = 0; k < NMOD; k++) v[off_of(k)] = 1'b1;
      return v;
   endfunction

   // position of the active line of one channel
   function automatic int unsigned oh_index(input logic [LINES-1:0] v,
                                            input int unsigned lo,
                                            input int unsigned m);
      int unsigned idx;
      idx = 0;
      for (int unsigned k = 0; k < LINES; k++)
         if (k < m && v[lo + k]) idx = k;
      return idx;
   endfunction

endpackage

// File: rtl/ohrns_bin2oh.sv
module ohrns_bin2oh
   import ohrns_pkg::*;
#(
   parameter int unsigned OP_W = 6
) (
   input  logic signed [OP_W-1:0] x,
   output logic [LINES-1:0]       oh
);

   logic [IDX_W-1:0] u;

   // offset value: x mod DYN in 0..DYN-1
   always_comb begin
      int xi;
      int r;
      xi = int'(x);
      r  = xi % int'(DYN);
      if (r < 0) r = r + int'(DYN);
      u = IDX_W'(r);
   end

   for (genvar c = 0; c < NMOD; c++) begin : g_chan
      localparam int unsigned LM = mod_of(c);
      localparam int unsigned LO = off_of(c);
      logic [LM-1:0] tab [DYN];
      for (genvar v = 0; v < DYN; v++) begin : g_ent
         assign tab[v] = LM'(1 << (v % LM));
      end
      assign oh[LO +: LM] = tab[u];
   end

endmodule

// File: rtl/ohrns_lane_add.sv
module ohrns_lane_add #(
   parameter int unsigned M        = 3,
   parameter int unsigned ROT_IMPL = 0
) (
   input  logic [M-1:0] a,
   input  logic [M-1:0] b,
   output logic [M-1:0] s,
   output logic         ok
);

   localparam int unsigned IW = (M > 1) ? $clog2(M) : 1;

   if (M < 2) begin : g_bad_mod
      $error("lane modulus must be at least 2");
   end

   assign ok = ($countones(a) == 1) && ($countones(b) == 1);

   if (ROT_IMPL == 0) begin : g_xbar
      // AND-OR crossbar: line k set when a[j] and b[(k-j) mod M]
      always_comb begin
         s = '0;
         for (int k = 0; k < int'(M); k++)
            for (int j = 0; j < int'(M); j++)
               s[k] = s[k] | (a[j] & b[(k + int'(M) - j) % int'(M)]);
      end
   end else begin : g_idx
      // encode b, then rotate a left by that amount
      logic [IW-1:0]  sh;
      logic [2*M-1:0] dbl;
      always_comb begin
         sh = '0;
         for (int j = 0; j < int'(M); j++)
            if (b[j]) sh = sh | IW'(j);
      end
      assign dbl = {a, a} << sh;
      assign s   = dbl[2*M-1:M];
   end

endmodule

// File: rtl/ohrns_oh_adder.sv
module ohrns_oh_adder
   import ohrns_pkg::*;
#(
   parameter int unsigned OP_W     = 6,
   parameter int unsigned ROT_IMPL = 0
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   valid_in,
   input  logic signed [OP_W-1:0] a_bin,
   input  logic signed [OP_W-1:0] b_bin,
   input  logic                   b_use_oh,
   input  logic [LINES-1:0]       b_oh,
   output logic                   valid_out,
   output logic [LINES-1:0]       sum_oh,
   output logic                   oh_err
);

   localparam logic [LINES-1:0] ZERO_OH = zero_code();

   if (!moduli_coprime()) begin : g_chk_cop
      $error("moduli are not pairwise coprime");
   end
   if (OP_W < 2 || OP_W > 30) begin : g_chk_w
      $error("OP_W out of supported range");
   end
   if ((64'd1 << (OP_W - 1)) < 64'(DYN / 2)) begin : g_chk_rng
      $error("OP_W too narrow for the signed dynamic range");
   end
   if (ROT_IMPL > 1) begin : g_chk_rot
      $error("ROT_IMPL must be 0 or 1");
   end

   logic [LINES-1:0] a_oh, b_cvt, b_sel, sum_nxt;
   logic [NMOD-1:0]  lane_ok;
   logic             in_bad, accept;

   ohrns_bin2oh #(.OP_W(OP_W)) u_cvt_a (.x(a_bin), .oh(a_oh));
   ohrns_bin2oh #(.OP_W(OP_W)) u_cvt_b (.x(b_bin), .oh(b_cvt));

   assign b_sel = b_use_oh ? b_oh : b_cvt;

   for (genvar i = 0; i < NMOD; i++) begin : g_lane
      localparam int unsigned LM = mod_of(i);
      localparam int unsigned LO = off_of(i);

      ohrns_lane_add #(.M(LM), .ROT_IMPL(ROT_IMPL)) u_lane (
         .a  (a_oh[LO +: LM]),
         .b  (b_sel[LO +: LM]),
         .s  (sum_nxt[LO +: LM]),
         .ok (lane_ok[i])
      );

      // R1: channel sum equals the residue sum of the operands
      assert_lane_sum_R1: assert property (@(posedge clk) disable iff (rst)
         accept |=> oh_index(sum_oh, LO, LM) ==
            ($past(oh_index(a_oh, LO, LM)) + $past(oh_index(b_sel, LO, LM))) % LM);

      // R1: every channel of the output stays one-hot
      assert_sum_onehot_R1: assert property (@(posedge clk) disable iff (rst)
         $onehot(sum_oh[LO +: LM]));
   end

   assign in_bad = ~&lane_ok;
   assign accept = valid_in & ~in_bad;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_out <= 1'b0;
         oh_err    <= 1'b0;
         sum_oh    <= ZERO_OH;
      end else begin
         valid_out <= accept;
         oh_err    <= valid_in & in_bad;
         if (accept) sum_oh <= sum_nxt;
      end
   end

   assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
      accept |=> valid_out && !oh_err);

   assert_bad_flag_R6: assert property (@(posedge clk) disable iff (rst)
      (valid_in && in_bad) |=> oh_err && !valid_out && $stable(sum_oh));

   assert_cvt_clean_R7: assert property (@(posedge clk) disable iff (rst)
      (valid_in && !b_use_oh) |=> !oh_err);

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !valid_in |=> !valid_out && !oh_err && $stable(sum_oh));

endmodule

// File: tb/sim_ohrns_oh_adder.sv
`timescale 1ns/1ps
module sim_ohrns_oh_adder;

   localparam int OP_W = 6;

   logic                   clk = 1'b0;
   logic                   rst = 1'b1;
   logic                   valid_in = 1'b0;
   logic signed [OP_W-1:0] a_bin = '0;
   logic signed [OP_W-1:0] b_bin = '0;
   logic                   b_use_oh = 1'b0;
   logic [11:0]            b_oh = '0;
   logic                   valid_out;
   logic [11:0]            sum_oh;
   logic                   oh_err;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   ohrns_oh_adder #(.OP_W(OP_W), .ROT_IMPL(1)) u0 (
      .clk(clk), .rst(rst), .valid_in(valid_in), .a_bin(a_bin), .b_bin(b_bin),
      .b_use_oh(b_use_oh), .b_oh(b_oh), .valid_out(valid_out),
      .sum_oh(sum_oh), .oh_err(oh_err)
   );

   // expected code: mod 3 at bits 2:0, mod 4 at 6:3, mod 5 at 11:7
   function automatic logic [11:0] enc(input int s);
      int v;
      logic [11:0] r;
      v = ((s % 60) + 60) % 60;
      r = '0;
      r[v % 3]     = 1'b1;
      r[3 + v % 4] = 1'b1;
      r[7 + v % 5] = 1'b1;
      return r;
   endfunction

   task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(input int a, input int b, input int s, input string req);
      valid_in = 1'b1;
      b_use_oh = 1'b0;
      a_bin    = OP_W'(a);
      b_bin    = OP_W'(b);
      @(negedge clk);
      chk({req, " valid"}, 12'(valid_out), 12'd1);
      chk({req, " err"},   12'(oh_err),    12'd0);
      chk({req, " sum"},   sum_oh,         enc(s));
      valid_in = 1'b0;
   endtask

   // a, b, expected (a + b) mod 60
   localparam int NV = 15;
   localparam int VEC [NV][3] = '{
      '{  0,   0,  0},
      '{  1,   1,  2},
      '{  5,   7, 12},
      '{ -1,  -1, 58},   // R2
      '{ -1,   1,  0},
      '{ 29,   2, 31},   // R3
      '{ 30,  30,  0},
      '{-29, -29,  2},
      '{ 13, -20, 53},
      '{ 30, -29,  1},
      '{ 17,  25, 42},
      '{-12,  -7, 41},
      '{-32,   0, 28},   // R10
      '{ 31,  31,  2},   // R10
      '{-30,  30,  0}    // R10
   };

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [11:0] bad;
      // R9: reset state
      repeat (2) @(negedge clk);
      chk("R9 valid", 12'(valid_out), 12'd0);
      chk("R9 err",   12'(oh_err),    12'd0);
      chk("R9 sum",   sum_oh,         12'h089);
      rst = 1'b0;

      // R1, R4: table walk, back to back
      for (int n = 0; n < NV; n++) run_op(VEC[n][0], VEC[n][1], VEC[n][2], "R1");

      // R2 and R3 directed
      run_op(-1, 0, 59, "R2");
      run_op(29, 2, -29, "R3");

      // R5: B from one-hot port, b_bin must not matter
      valid_in = 1'b1; b_use_oh = 1'b1; a_bin = OP_W'(10); b_bin = OP_W'(20); b_oh = enc(7);
      @(negedge clk);
      chk("R5 valid", 12'(valid_out), 12'd1);
      chk("R5 sum",   sum_oh,         enc(17));
      a_bin = OP_W'(-5); b_bin = OP_W'(-3); b_oh = enc(58);
      @(negedge clk);
      chk("R5 sum neg", sum_oh, enc(53));

      // R6: missing bit in the modulus-4 channel
      bad = enc(7) & ~12'h078;
      b_oh = bad; a_bin = OP_W'(1);
      @(negedge clk);
      chk("R6 err",   12'(oh_err),    12'd1);
      chk("R6 valid", 12'(valid_out), 12'd0);
      chk("R6 hold",  sum_oh,         enc(53));
      // R6: extra bit in the modulus-5 channel
      b_oh = enc(7) | 12'h800;
      @(negedge clk);
      chk("R6 multi err",  12'(oh_err), 12'd1);
      chk("R6 multi hold", sum_oh,      enc(53));

      // R8: idle cycle clears flags and holds sum
      valid_in = 1'b0; a_bin = OP_W'(9); b_bin = OP_W'(9);
      @(negedge clk);
      chk("R8 valid", 12'(valid_out), 12'd0);
      chk("R8 err",   12'(oh_err),    12'd0);
      chk("R8 hold",  sum_oh,         enc(53));

      // R7: malformed b_oh ignored when not selected
      valid_in = 1'b1; b_use_oh = 1'b0; b_oh = '0; a_bin = OP_W'(3); b_bin = OP_W'(4);
      @(negedge clk);
      chk("R7 err",   12'(oh_err),    12'd0);
      chk("R7 valid", 12'(valid_out), 12'd1);
      chk("R7 sum",   sum_oh,         enc(7));

      // R8: idle with changed operands
      valid_in = 1'b0; a_bin = OP_W'(-20); b_bin = OP_W'(11);
      @(negedge clk);
      chk("R8 idle hold", sum_oh, enc(7));

      // R9: reset during a request
      rst = 1'b1; valid_in = 1'b1;
      @(negedge clk);
      chk("R9 mid valid", 12'(valid_out), 12'd0);
      chk("R9 mid err",   12'(oh_err),    12'd0);
      chk("R9 mid sum",   sum_oh,         12'h089);
      rst = 1'b0; valid_in = 1'b0;
      @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule